// File: doc/BRIEF.md
# Fast Ethernet Transmit Coder with 4B/5B Framing and NRZI Line Output

This block turns the nibble-wide transmit side of a Fast Ethernet media-independent interface into a serial line stream. It runs on a single 125 MHz bit clock and derives the 25 MHz nibble rate from it with a divide-by-five phase counter. The counter is exported as a one-cycle strobe so the sender knows when each nibble is taken. In every five-bit symbol slot the block emits one 5-bit code group. It sends idle fill between packets, a two-symbol start delimiter that replaces the first preamble nibbles, a 4B/5B code for each data nibble, and a two-symbol end delimiter when the enable drops. When the error input is raised together with the enable, every slot is replaced by the Halt code.

The chosen code group is shifted out most significant bit first. It then passes through an NRZ-to-NRZI stage, so the line level toggles for every 1 bit and holds for every 0 bit.

Top module: `mii_tx_pcs`

## Requirements
- R1: While reset is asserted and directly after it, `lineOut` is 0, and the first slot after reset carries the idle code 11111.
- R2: `nibbleTick` is high for exactly one bit-clock cycle in every five. The data, enable and error inputs are sampled at the rising edge that ends that cycle, which is the slot boundary.
- R3: While the enable stays low and no end delimiter is pending, every slot carries the idle code 11111.
- R4: An enable sampled high while idle starts a packet: that slot carries J (11000) and the next slot carries K (10001). The nibbles presented in those two slots are not transmitted.
- R5: From the third enabled slot on, each nibble is sent as its data code (nibble:code) 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101.
- R6: A code chosen at slot boundary E is sent bit 4 first. Bit k of the five leaves as a toggle (for 1) or no toggle (for 0) of `lineOut` at bit-clock edge E+5-k.
- R7: The first slot sampled with the enable low after data slots carries T (01101). The next slot carries R (00111) whatever the inputs are, except as R8 says, and idle resumes after it.
- R8: In any slot where enable and error are both sampled high, the slot carries Halt (00100). The packet sequencing advances as if the normal code had been sent.
- R9: When the enable is sampled low, the error input has no effect on the code sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| txData | input | 4 | Transmit nibble |
| txEnable | input | 1 | Packet in progress |
| txError | input | 1 | Force Halt code while enabled |
| nibbleTick | output | 1 | High in the last bit cycle of each slot |
| lineOut | output | 1 | NRZI serial line level |

## Verification
A scoreboard rebuilds each 5-bit group from the line transitions and compares it with the code that the requirements predict for the sampled inputs. The first packet walks all sixteen nibble values, which separates table errors, bit order errors and NRZI errors. A one-nibble packet and a packet that is re-enabled right after T exercise the delimiter sequencing at its tightest spacing. The error input is raised both inside a packet and between packets, which separates the Halt override from the case where the error must be ignored.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = 5;

  localparam logic [SYM_W-1:0] CODE_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] CODE_J    = 5'b11000;
  localparam logic [SYM_W-1:0] CODE_K    = 5'b10001;
  localparam logic [SYM_W-1:0] CODE_T    = 5'b01101;
  localparam logic [SYM_W-1:0] CODE_R    = 5'b00111;
  localparam logic [SYM_W-1:0] CODE_H    = 5'b00100;

  typedef enum logic [2:0] {
    SEL_IDLE, SEL_J, SEL_K, SEL_T, SEL_R, SEL_H, SEL_DATA
  } codeSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     load;
    codeSel_t sel;
  } txStrobe_t;

  function automatic logic [SYM_W-1:0] dataCode(input logic [NIB_W-1:0] nib);
    case (nib)
      4'h0: dataCode = 5'b11110;
      4'h1: dataCode = 5'b01001;
      4'h2: dataCode = 5'b10100;
      4'h3: dataCode = 5'b10101;
      4'h4: dataCode = 5'b01010;
      4'h5: dataCode = 5'b01011;
      4'h6: dataCode = 5'b01110;
      4'h7: dataCode = 5'b01111;
      4'h8: dataCode = 5'b10010;
      4'h9: dataCode = 5'b10011;
      4'hA: dataCode = 5'b10110;
      4'hB: dataCode = 5'b10111;
      4'hC: dataCode = 5'b11010;
      4'hD: dataCode = 5'b11011;
      4'hE: dataCode = 5'b11100;
      default: dataCode = 5'b11101;
    endcase
  endfunction
endpackage

// File: rtl/mii_tx_ctl.sv
module mii_tx_ctl
  import mii_tx_pkg::*;
#(
  parameter int SLOT_LEN = SYM_W
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEnable,
  input  logic      txError,
  output logic      nibbleTick,
  output txStrobe_t strobe
);
  localparam int PH_W = $clog2(SLOT_LEN);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_LEN - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND_K, ST_DATA, ST_SEND_R} txState_t;

  logic [PH_W-1:0] phase;
  txState_t        state, stateNext;
  codeSel_t        selNormal;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= '0;
    else if (phase == PH_LAST) phase <= '0;
    else phase <= phase + 1'b1;
  end

  assign nibbleTick = (phase == PH_LAST);

  always_comb begin
    stateNext = state;
    selNormal = SEL_IDLE;
    case (state)
      ST_IDLE: if (txEnable) begin
        selNormal = SEL_J;
        stateNext = ST_SEND_K;
      end
      ST_SEND_K: begin
        selNormal = SEL_K;
        stateNext = ST_DATA;
      end
      ST_DATA: if (txEnable) begin
        selNormal = SEL_DATA;
      end else begin
        selNormal = SEL_T;
        stateNext = ST_SEND_R;
      end
      default: begin
        selNormal = SEL_R;
        stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else if (nibbleTick) state <= stateNext;
  end

  always_comb begin
    strobe.load = nibbleTick;
    strobe.sel  = (txEnable && txError) ? SEL_H : selNormal;
  end
endmodule

// File: rtl/mii_tx_dp.sv
module mii_tx_dp
  import mii_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  txStrobe_t        strobe,
  input  logic [NIB_W-1:0] txData,
  output logic             lineOut
);
  logic [SYM_W-1:0] shiftReg;
  logic [SYM_W-1:0] nextCode;
  logic             nrziLevel;

  always_comb begin
    case (strobe.sel)
      SEL_J:    nextCode = CODE_J;
      SEL_K:    nextCode = CODE_K;
      SEL_T:    nextCode = CODE_T;
      SEL_R:    nextCode = CODE_R;
      SEL_H:    nextCode = CODE_H;
      SEL_DATA: nextCode = dataCode(txData);
      default:  nextCode = CODE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= CODE_IDLE;
      nrziLevel <= 1'b0;
    end else begin
      nrziLevel <= nrziLevel ^ shiftReg[SYM_W-1];
      if (strobe.load) shiftReg <= nextCode;
      else shiftReg <= {shiftReg[SYM_W-2:0], 1'b0};
    end
  end

  assign lineOut = nrziLevel;
endmodule

// File: rtl/mii_tx_pcs.sv
module mii_tx_pcs
  import mii_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] txData,
  input  logic       txEnable,
  input  logic       txError,
  output logic       nibbleTick,
  output logic       lineOut
);
  txStrobe_t strobe;

  mii_tx_ctl #(.SLOT_LEN(SYM_W)) u_ctl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .txError(txError),
    .nibbleTick(nibbleTick), .strobe(strobe)
  );

  mii_tx_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txData(txData),
    .lineOut(lineOut)
  );
endmodule

// File: rtl/mii_tx_pcs_chk.sv
module mii_tx_pcs_chk (
  input logic clk,
  input logic rstN,
  input logic txEnable,
  input logic txError,
  input logic nibbleTick,
  input logic lineOut
);
  logic [2:0] sinceTick;
  logic [4:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceTick <= '0;
      sinceRst  <= '0;
    end else begin
      sinceTick <= nibbleTick ? 3'd0 : sinceTick + 3'd1;
      if (sinceRst != 5'd31) sinceRst <= sinceRst + 5'd1;
    end
  end

  // R2
  slot_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    nibbleTick |-> sinceTick == 3'd4);

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    nibbleTick |=> !nibbleTick);

  // R8
  halt_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nibbleTick && txEnable && txError) |->
      ##2 $stable(lineOut) ##1 $stable(lineOut) ##1 !$stable(lineOut)
      ##1 $stable(lineOut) ##1 $stable(lineOut));

  // R3
  idle_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 5'd20 && nibbleTick && !txEnable && !$past(txEnable, 5)
     && !$past(txEnable, 10) && !$past(txEnable, 15)) |->
      ##2 !$stable(lineOut) ##1 !$stable(lineOut) ##1 !$stable(lineOut)
      ##1 !$stable(lineOut) ##1 !$stable(lineOut));
endmodule

bind mii_tx_pcs mii_tx_pcs_chk u_chk (
  .clk(clk), .rstN(rstN), .txEnable(txEnable), .txError(txError),
  .nibbleTick(nibbleTick), .lineOut(lineOut)
);

// File: tb/sim_mii_tx_pcs.sv
module sim_mii_tx_pcs;
  localparam time CLK_PERIOD = 8ns;
  localparam int  WATCHDOG_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] txData = 4'h0;
  logic       txEnable = 1'b0;
  logic       txError = 1'b0;
  logic       nibbleTick;
  logic       lineOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [4:0] expQ[$];
  string      tagQ[$];

  logic [4:0] dataTab [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};

  int  benchState = 0; // 0 idle, 1 K pending, 2 data, 3 R pending
  bit  firstSlot = 1'b1;

  mii_tx_pcs u0 (
    .clk(clk), .rstN(rstN), .txData(txData), .txEnable(txEnable),
    .txError(txError), .nibbleTick(nibbleTick), .lineOut(lineOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [4:0] act,
                       input logic [4:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic slot(input bit en, input bit er, input logic [3:0] d);
    logic [4:0] code;
    string tag;
    do @(negedge clk); while (!nibbleTick);
    if (firstSlot) begin
      expQ.push_back(5'b11111);
      tagQ.push_back("R1");
      firstSlot = 1'b0;
    end
    txEnable = en;
    txError  = er;
    txData   = d;
    case (benchState)
      0: if (en) begin code = 5'b11000; tag = "R4"; benchState = 1; end
         else begin code = 5'b11111; tag = er ? "R9" : "R3"; end
      1: begin code = 5'b10001; tag = "R4"; benchState = 2; end
      2: if (en) begin code = dataTab[d]; tag = "R5 R6"; end
         else begin code = 5'b01101; tag = er ? "R7 R9" : "R7"; benchState = 3; end
      default: begin code = 5'b00111; tag = "R7"; benchState = 0; end
    endcase
    if (en && er) begin code = 5'b00100; tag = "R8"; end
    expQ.push_back(code);
    tagQ.push_back(tag);
  endtask

  // monitor: rebuild code groups from NRZI transitions
  initial begin
    logic       prevLine = 1'b0;
    bit         prevTick = 1'b0;
    bit         seenTick = 1'b0;
    int         gap = 0;
    logic [4:0] coll = '0;
    logic [4:0] exp;
    string      tag;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        prevLine = lineOut;
        continue;
      end
      coll = {coll[3:0], lineOut ^ prevLine};
      prevLine = lineOut;
      if (prevTick && expQ.size() > 0) begin
        exp = expQ.pop_front();
        tag = tagQ.pop_front();
        check(coll == exp, tag, coll, exp);
      end
      gap++;
      if (nibbleTick) begin
        if (seenTick) check(gap == 5, "R2", 5'(gap), 5'd5);
        seenTick = 1'b1;
        gap = 0;
      end
      prevTick = nibbleTick;
    end
  end

  // watchdog
  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (6) @(negedge clk);
    check(lineOut == 1'b0, "R1", {4'b0, lineOut}, 5'd0);
    rstN = 1'b1;

    // idle, error alone is ignored (R3, R9)
    slot(0, 0, 4'h0);
    slot(0, 1, 4'h5);
    slot(0, 0, 4'h0);
    slot(0, 1, 4'hA);

    // packet walking all nibbles (R4, R5, R6, R7)
    slot(1, 0, 4'h5);
    slot(1, 0, 4'h5);
    for (int n = 0; n < 16; n++) slot(1, 0, 4'(n));
    slot(0, 0, 4'h0);
    slot(0, 0, 4'h0);
    slot(0, 0, 4'h0);

    // one-nibble packet (R4, R7)
    slot(1, 0, 4'h3);
    slot(1, 0, 4'h3);
    slot(1, 0, 4'h9);
    slot(0, 1, 4'h0);
    slot(0, 0, 4'h0);
    slot(0, 0, 4'h0);

    // Halt override inside a packet and on the start slot (R8)
    slot(1, 1, 4'h0);
    slot(1, 0, 4'h0);
    slot(1, 0, 4'h7);
    slot(1, 1, 4'h7);
    slot(1, 1, 4'hC);
    slot(1, 0, 4'hC);
    slot(0, 0, 4'h0);

    // re-enable during the R slot: ignored, start one slot later (R7)
    slot(1, 0, 4'h2);
    slot(1, 0, 4'h5);
    slot(1, 0, 4'h5);
    slot(1, 0, 4'hE);
    slot(0, 0, 4'h0);
    for (int i = 0; i < 5; i++) slot(0, 0, 4'h0);

    repeat (15) @(negedge clk);
    check(expQ.size() == 0, "R6", 5'(expQ.size()), 5'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule